// File: doc/BRIEF.md
# Issue-Select Arbiter Tree

This block is the select stage of an issue queue. Every queue entry presents one ready bit. In each cycle the block raises exactly one word line, for the lowest-numbered ready entry, so that the payload of that entry can be read out and sent to a functional unit. It raises no word line when no entry is ready or when issue is disabled.

The selection is not a single flat priority encoder. It is a tree of identical fixed-priority cells, each with a small fan-in. A cell passes the OR of its requests up to its parent as a group request. The parent's grant comes back down and gates the cell's local fixed-priority choice. The root cell's grant input is the issue-enable signal. With the defaults (12 entries, fan-in 4) the tree has three leaf cells under one root, and the root's fourth request input is held at 0. The logic is purely combinational, so the word lines follow the ready bits within the same cycle.

Top module: `iss_sel_tree`

## Requirements
- R1: At most one bit of `word_line` is high for every combination of `entry_ready` and `issue_en`.
- R2: When `issue_en` is 1 and at least one entry is ready, `word_line` is one-hot at the lowest index i for which `entry_ready[i]` is 1. Bit i of `word_line` selects entry i, and entry 0 has the highest priority.
- R3: When `issue_en` is 0, `word_line` is all zeros, whatever the ready bits are.
- R4: When `entry_ready` is all zeros, `word_line` is all zeros.
- R5: `any_ready` is 1 exactly when at least one `entry_ready` bit is 1, independent of `issue_en`.
- R6: A `word_line` bit is never high for an entry whose ready bit is 0.
- R7: Priority holds across leaf groups. Entries 0..3 form leaf group 0, entries 4..7 form group 1 and entries 8..11 form group 2. A ready entry in a lower-numbered group wins over every ready entry in a higher-numbered group, however many of those are ready.
- R8: The grant is combinational: a change of `entry_ready` or `issue_en` shows on `word_line` and `any_ready` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| issue_en | input | 1 | Functional unit can accept an instruction; grant input of the root cell |
| entry_ready | input | NUM_ENTRIES | One ready bit per issue-queue entry |
| word_line | output | NUM_ENTRIES | One-hot read select of the granted entry |
| any_ready | output | 1 | Group request of the root: some entry is ready |

## Verification
Two functions can meet in the same cycle: the local choice inside a leaf cell, and the gating by the root's grant when several leaves request at once. When a higher group holds more ready entries than a lower group, the two must still agree on one winner. The bench provokes this by sweeping all 4096 ready patterns, once with issue enabled and once with it disabled, and adds directed patterns that load the upper groups heavily. Each result is judged against a lowest-set-bit value the bench computes arithmetically from the pattern.

// File: rtl/iss_sel_pkg.sv
package iss_sel_pkg;

  // integer power, base^exp, exp >= 0
  function automatic int ipow(input int base, input int exp);
    int acc;
    acc = 1;
    for (int k = 0; k < exp; k++) acc = acc * base;
    return acc;
  endfunction

  // number of tree levels needed so that fanin^levels >= entries
  function automatic int tree_levels(input int entries, input int fanin);
    int lv;
    int span;
    lv   = 1;
    span = fanin;
    while (span < entries) begin
      span = span * fanin;
      lv++;
    end
    return lv;
  endfunction

  // cells instantiated at level lv (0 = leaves)
  function automatic int cells_at(input int entries, input int fanin, input int lv);
    int span;
    span = ipow(fanin, lv + 1);
    return (entries + span - 1) / span;
  endfunction

  // index of the first cell of level lv in the flat cell numbering
  function automatic int cell_base(input int entries, input int fanin, input int lv);
    int sum;
    sum = 0;
    for (int k = 0; k < lv; k++) sum = sum + cells_at(entries, fanin, k);
    return sum;
  endfunction

endpackage

// File: rtl/iss_sel_cell.sv
module iss_sel_cell #(
  parameter int FANIN = 4
) (
  input  logic             grant_in,
  input  logic [FANIN-1:0] req,
  output logic [FANIN-1:0] gnt,
  output logic             grp_req
);

  logic [FANIN:0] lower_busy;

  // lower index wins; lower_busy[i] marks a request below position i
  always_comb begin
    lower_busy[0] = 1'b0;
    for (int i = 0; i < FANIN; i++) begin
      gnt[i]            = grant_in & req[i] & ~lower_busy[i];
      lower_busy[i + 1] = lower_busy[i] | req[i];
    end
  end

  assign grp_req = lower_busy[FANIN];

  always_comb begin
    AST_CELL_ONE_GRANT: assert ($onehot0(gnt)); // R1
    if (!grant_in) begin
      AST_CELL_GATED: assert (gnt == '0); // R3
    end
    if (gnt != '0) begin
      AST_CELL_GROUP_UP: assert (grp_req); // R5
    end
  end

endmodule

// File: rtl/iss_sel_level.sv
module iss_sel_level #(
  parameter int FANIN = 4,
  parameter int CELLS = 1
) (
  input  logic [CELLS*FANIN-1:0] req,
  input  logic [CELLS-1:0]       grant_in,
  output logic [CELLS*FANIN-1:0] gnt,
  output logic [CELLS-1:0]       grp_req
);

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    iss_sel_cell #(
      .FANIN(FANIN)
    ) u_cell (
      .grant_in (grant_in[c]),
      .req      (req[c*FANIN +: FANIN]),
      .gnt      (gnt[c*FANIN +: FANIN]),
      .grp_req  (grp_req[c])
    );
  end

endmodule

// File: rtl/iss_sel_tree.sv
module iss_sel_tree
  import iss_sel_pkg::*;
#(
  parameter int NUM_ENTRIES = 12,
  parameter int FANIN       = 4
) (
  input  logic                   issue_en,
  input  logic [NUM_ENTRIES-1:0] entry_ready,
  output logic [NUM_ENTRIES-1:0] word_line,
  output logic                   any_ready
);

  localparam int LEVELS      = tree_levels(NUM_ENTRIES, FANIN);
  localparam int TOTAL_CELLS = cell_base(NUM_ENTRIES, FANIN, LEVELS);
  localparam int ROOT        = TOTAL_CELLS - 1;

  // flat storage for every cell in the tree, leaves first, root last
  logic [TOTAL_CELLS*FANIN-1:0] req_flat;
  logic [TOTAL_CELLS*FANIN-1:0] gnt_flat;
  logic [TOTAL_CELLS-1:0]       grp_flat;
  logic [TOTAL_CELLS-1:0]       gg_flat;

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
    localparam int CELLS   = cells_at(NUM_ENTRIES, FANIN, lv);
    localparam int BASE    = cell_base(NUM_ENTRIES, FANIN, lv);
    localparam int SRC_W   = (lv == 0) ? NUM_ENTRIES : cells_at(NUM_ENTRIES, FANIN, lv - 1);
    localparam int SRC_B   = (lv == 0) ? 0 : cell_base(NUM_ENTRIES, FANIN, lv - 1);

    // request inputs: ready bits at the leaves, child group requests above
    for (genvar j = 0; j < CELLS*FANIN; j++) begin : g_req
      if (j < SRC_W) begin : g_live
        if (lv == 0) begin : g_leaf
          assign req_flat[BASE*FANIN + j] = entry_ready[j];
        end else begin : g_inner
          assign req_flat[BASE*FANIN + j] = grp_flat[SRC_B + j];
        end
      end else begin : g_pad
        assign req_flat[BASE*FANIN + j] = 1'b0;
      end
    end

    // grant inputs: issue enable at the root, parent grants below
    if (lv == LEVELS - 1) begin : g_root_gg
      assign gg_flat[BASE] = issue_en;
    end else begin : g_child_gg
      localparam int PAR_B = cell_base(NUM_ENTRIES, FANIN, lv + 1);
      for (genvar c = 0; c < CELLS; c++) begin : g_gg
        assign gg_flat[BASE + c] = gnt_flat[PAR_B*FANIN + c];
      end
    end

    iss_sel_level #(
      .FANIN (FANIN),
      .CELLS (CELLS)
    ) u_level (
      .req      (req_flat[BASE*FANIN +: CELLS*FANIN]),
      .grant_in (gg_flat[BASE +: CELLS]),
      .gnt      (gnt_flat[BASE*FANIN +: CELLS*FANIN]),
      .grp_req  (grp_flat[BASE +: CELLS])
    );
  end

  assign word_line = gnt_flat[NUM_ENTRIES-1:0];
  assign any_ready = grp_flat[ROOT];

  always_comb begin
    AST_ONE_WORD_LINE: assert ($onehot0(word_line)); // R1
    AST_TREE_PATH: assert ($countones(gnt_flat) <= LEVELS); // R1
    AST_GRANT_IS_READY: assert ((word_line & ~entry_ready) == '0); // R6
    AST_ANY_READY: assert (any_ready == (entry_ready != '0)); // R5
    if (!issue_en) begin
      AST_DISABLED_IDLE: assert (word_line == '0); // R3
    end
    if (entry_ready == '0) begin
      AST_EMPTY_IDLE: assert (word_line == '0); // R4
    end
    if (issue_en && (entry_ready != '0)) begin
      AST_GRANT_WHEN_READY: assert (word_line != '0); // R2
      AST_LOWEST_WINS: assert (((word_line - 1'b1) & entry_ready) == '0); // R7
    end
  end

endmodule

// File: tb/test_iss_sel_tree.sv
`timescale 1ns/1ps
module test_iss_sel_tree;

  localparam int N = 12;

  logic         clk;
  logic         issue_en;
  logic [N-1:0] entry_ready;
  logic [N-1:0] word_line;
  logic         any_ready;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  iss_sel_tree #(
    .NUM_ENTRIES (N),
    .FANIN       (4)
  ) i_iss_sel_tree (
    .issue_en    (issue_en),
    .entry_ready (entry_ready),
    .word_line   (word_line),
    .any_ready   (any_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s en=%0b ready=%03h actual=%0h expected=%0h",
               tag, issue_en, entry_ready, act, exp);
    end
  endtask

  function automatic logic [N-1:0] lowest(input logic [N-1:0] r);
    return r & (~r + 1'b1);
  endfunction

  task automatic apply_and_check(input logic en, input logic [N-1:0] r, input string tag);
    @(posedge clk);
    issue_en    = en;
    entry_ready = r;
    @(negedge clk);
    chk(tag, 32'(word_line), en ? 32'(lowest(r)) : 32'd0);
  endtask

  initial begin
    issue_en    = 1'b0;
    entry_ready = '0;
    @(negedge clk);
    // idle state: nothing ready, issue off
    chk("R4 idle word_line", 32'(word_line), 32'd0);
    chk("R5 idle any_ready", 32'(any_ready), 32'd0);

    // exhaustive sweep, issue enabled then disabled
    for (int e = 1; e >= 0; e--) begin
      for (int p = 0; p < (1 << N); p++) begin
        logic [N-1:0] r;
        logic [N-1:0] exp_wl;
        r      = N'(p);
        exp_wl = (e == 1) ? lowest(r) : '0;
        @(posedge clk);
        issue_en    = e[0];
        entry_ready = r;
        @(negedge clk);
        if (e == 0)       chk("R3 disabled", 32'(word_line), 32'd0);
        else if (p == 0)  chk("R4 none ready", 32'(word_line), 32'd0);
        else              chk("R2 lowest ready", 32'(word_line), 32'(exp_wl));
        chk("R1 at most one", 32'($countones(word_line) <= 1), 32'd1);
        chk("R6 only ready", 32'(word_line & ~r), 32'd0);
        chk("R5 any_ready", 32'(any_ready), 32'(r != '0));
      end
    end

    // cross-group priority
    apply_and_check(1'b1, 12'hF10, "R7 group1 beats full group2");
    apply_and_check(1'b1, 12'hFF8, "R7 group0 top beats groups1-2");
    apply_and_check(1'b1, 12'hF00, "R7 only group2");
    apply_and_check(1'b1, 12'h800, "R7 last entry alone");
    apply_and_check(1'b1, 12'h0F0, "R7 group1 lowest");

    // same-cycle response without a clock edge
    @(negedge clk);
    issue_en    = 1'b1;
    entry_ready = 12'h0A0;
    #1;
    chk("R8 comb grant", 32'(word_line), 32'h020);
    entry_ready = 12'h0A4;
    #1;
    chk("R8 comb regrant", 32'(word_line), 32'h004);
    issue_en = 1'b0;
    #1;
    chk("R8 comb disable", 32'(word_line), 32'd0);
    chk("R8 comb any_ready", 32'(any_ready), 32'd1);
    entry_ready = '0;
    #1;
    chk("R8 comb any_ready clear", 32'(any_ready), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule